// File: doc/BRIEF.md
# Serial-to-Parallel Capture Lane with Word Slip

This block turns a one-bit serial input into parallel words. The word width is fixed at build time and may be any value from 4 to 10 bits. Serial bits are taken on the rising edge of a fast serial clock. A word is assembled once every width-count serial cycles and then moved into an output register clocked by a slower parallel clock. Two bypass variants replace the word path. One is a 2-bit double-edge capture and the other is a 1-bit single-edge register.

Word alignment is adjusted from outside. Each rising edge on the alignment request delays the incoming stream by one more bit, which moves the word boundary by one bit-time. After a preset number of slips the delay returns to zero, which restores the original alignment. The block then raises a wrap flag for exactly one parallel-clock cycle. The slip counter and the wrap flag work in every variant. In the bypass variants the slips do not change the data.

Top module: `serial_word_capture`

## Requirements
- R1: In word mode, `word_o` carries FACTOR consecutive delayed serial bits, with the earliest in bit FACTOR-1. A new word is formed once every FACTOR serial cycles and is copied into `word_o` on the next rising edge of `clk_par`.
- R2: A slip takes effect only on a rising edge of the request. Let E be the first `clk_ser` edge that samples `align_req` high after it was low. The slip position advances at edge E+2. From edge E+3 on, the stream feeding the word path is delayed by one more bit. With a periodic pattern, the word is then the previous word rotated right by one.
- R3: The slip position counts 0 to WRAP-1, and the slip after WRAP-1 returns it to 0. After WRAP slips the word alignment is the same as before the first slip.
- R4: Each return to position 0 makes `wrap_o` high for exactly one `clk_par` cycle. At no other time is `wrap_o` high.
- R5: In DDR mode, `word_o` is 2 bits. Bit 1 holds the input sampled at a rising `clk_ser` edge, and bit 0 holds the input sampled at the falling edge that follows. Both appear together at the next rising edge of `clk_par`, which runs on the same clock as `clk_ser` in this mode.
- R6: In SDR mode, `word_o` is 1 bit and equals `ser_in` as sampled at the previous rising edge of `clk_par`.
- R7: While `rst` is high, `word_o`, `wrap_o`, the slip position, and all shift and history state are cleared at each clock edge.
- R8: In the two bypass modes, slip requests leave `word_o` unchanged. `wrap_o` still reports each wrap as in R4.
- R9: Holding `align_req` high for many cycles produces a single slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast serial bit clock |
| clk_par | input | 1 | Parallel word clock (equals `clk_ser` in bypass modes) |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ser_in | input | 1 | Serial data input |
| align_req | input | 1 | Word-slip request, acts on its rising edge |
| word_o | output | OUT_W | Parallel word (FACTOR, 2 or 1 bits by mode) |
| wrap_o | output | 1 | One-parallel-cycle pulse when the slip position wraps |

## Verification
The assertions check on every cycle that the slip position only steps by one or returns to zero, and that it returns to zero only from WRAP-1. They also check that a held request cannot produce two slips in a row, that the wrap pulse never lasts two parallel cycles, and that the word register changes only on its load cycle. Only the bench scenarios can show the data-level behaviour. These include which bit lands in which position, the one-bit rotation after each slip, the return to the original word after a full wrap, and the fact that bypass data does not respond to slips. The bench compares all three variants against a behavioural model on every serial cycle.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

  typedef enum logic [1:0] {
    CAP_WORD = 2'd0,
    CAP_DDR  = 2'd1,
    CAP_SDR  = 2'd2
  } cap_mode_e;

  function automatic int unsigned lane_width(cap_mode_e m, int unsigned f);
    case (m)
      CAP_DDR: return 2;
      CAP_SDR: return 1;
      default: return f;
    endcase
  endfunction

endpackage

// File: rtl/sdes_slip_ctrl.sv
module sdes_slip_ctrl #(
  parameter int unsigned WRAP = 4,
  localparam int unsigned POS_W = (WRAP > 1) ? $clog2(WRAP) : 1
) (
  input  logic             clk_ser,
  input  logic             clk_par,
  input  logic             rst,
  input  logic             req,
  output logic [POS_W-1:0] pos,
  output logic             wrap_o
);

  logic [2:0] req_sync;
  logic       go;
  logic       tgl;
  logic [2:0] tgl_sync;

  always_ff @(posedge clk_ser) begin
    if (rst) req_sync <= '0;
    else     req_sync <= {req_sync[1:0], req};
  end

  assign go = req_sync[1] & ~req_sync[2];

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      pos <= '0;
      tgl <= 1'b0;
    end else if (go) begin
      if (pos == POS_W'(WRAP - 1)) begin
        pos <= '0;
        tgl <= ~tgl;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_par) begin
    if (rst) begin
      tgl_sync <= '0;
      wrap_o   <= 1'b0;
    end else begin
      tgl_sync <= {tgl_sync[1:0], tgl};
      wrap_o   <= tgl_sync[1] ^ tgl_sync[2];
    end
  end

  // R2: position moves only by one step forward or back to zero
  p_pos_step_r2: assert property (@(posedge clk_ser) disable iff (rst)
    (pos != $past(pos)) |-> (pos == $past(pos) + 1'b1 || pos == '0));

  // R3: return to zero happens only from the last position
  p_wrap_from_top_r3: assert property (@(posedge clk_ser) disable iff (rst)
    (pos == '0 && $past(pos) != '0) |-> ($past(pos) == POS_W'(WRAP - 1)));

  // R9: a request never yields two slips on consecutive cycles
  p_single_slip_r9: assert property (@(posedge clk_ser) disable iff (rst)
    (pos != $past(pos)) |=> (pos == $past(pos)));

  // R4: wrap flag lasts one parallel cycle
  p_pulse_one_r4: assert property (@(posedge clk_par) disable iff (rst)
    wrap_o |=> !wrap_o);

endmodule

// File: rtl/sdes_bit_slip.sv
module sdes_bit_slip #(
  parameter int unsigned WRAP = 4,
  localparam int unsigned POS_W = (WRAP > 1) ? $clog2(WRAP) : 1,
  localparam int unsigned DEPTH = (WRAP > 1) ? WRAP - 1 : 1
) (
  input  logic             clk_ser,
  input  logic             rst,
  input  logic             ser_in,
  input  logic [POS_W-1:0] pos,
  output logic             dbit
);

  logic [DEPTH-1:0] hist;

  generate
    if (DEPTH > 1) begin : g_line
      always_ff @(posedge clk_ser) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], ser_in};
      end
    end else begin : g_single
      always_ff @(posedge clk_ser) begin
        if (rst) hist <= '0;
        else     hist <= ser_in;
      end
    end
  endgenerate

  always_comb begin
    dbit = ser_in;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(pos) == i + 1) dbit = hist[i];
    end
  end

endmodule

// File: rtl/sdes_word_deser.sv
module sdes_word_deser #(
  parameter int unsigned FACTOR = 8,
  localparam int unsigned CNT_W = $clog2(FACTOR)
) (
  input  logic              clk_ser,
  input  logic              clk_par,
  input  logic              rst,
  input  logic              dbit,
  output logic [FACTOR-1:0] word_o
);

  logic [FACTOR-1:0] sr;
  logic [FACTOR-1:0] hold;
  logic [CNT_W-1:0]  cnt;
  logic              load;

  assign load = (cnt == CNT_W'(FACTOR - 1));

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      sr   <= '0;
      hold <= '0;
      cnt  <= '0;
    end else begin
      sr  <= {sr[FACTOR-2:0], dbit};
      cnt <= load ? '0 : cnt + 1'b1;
      if (load) hold <= {sr[FACTOR-2:0], dbit};
    end
  end

  always_ff @(posedge clk_par) begin
    if (rst) word_o <= '0;
    else     word_o <= hold;
  end

  // R1: the word holding register moves only on its load cycle
  p_load_only_r1: assert property (@(posedge clk_ser) disable iff (rst)
    (hold != $past(hold)) |-> ($past(cnt) == CNT_W'(FACTOR - 1)));

endmodule

// File: rtl/sdes_ddr_lane.sv
module sdes_ddr_lane (
  input  logic       clk_ser,
  input  logic       clk_par,
  input  logic       rst,
  input  logic       ser_in,
  output logic [1:0] word_o
);

  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_ser) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= ser_in;
  end

  always_ff @(negedge clk_ser) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= ser_in;
  end

  always_ff @(posedge clk_par) begin
    if (rst) word_o <= '0;
    else     word_o <= {rise_q, fall_q};
  end

endmodule

// File: rtl/serial_word_capture.sv
module serial_word_capture #(
  parameter sdes_pkg::cap_mode_e MODE = sdes_pkg::CAP_WORD,
  parameter int unsigned FACTOR = 8,
  parameter int unsigned WRAP   = 4,
  localparam int unsigned OUT_W = sdes_pkg::lane_width(MODE, FACTOR),
  localparam int unsigned POS_W = (WRAP > 1) ? $clog2(WRAP) : 1
) (
  input  logic             clk_ser,
  input  logic             clk_par,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             align_req,
  output logic [OUT_W-1:0] word_o,
  output logic             wrap_o
);

  logic [POS_W-1:0] slip_pos;

  sdes_slip_ctrl #(.WRAP(WRAP)) u_slip (
    .clk_ser (clk_ser),
    .clk_par (clk_par),
    .rst     (rst),
    .req     (align_req),
    .pos     (slip_pos),
    .wrap_o  (wrap_o)
  );

  generate
    if (MODE == sdes_pkg::CAP_WORD) begin : g_word
      logic dbit;
      sdes_bit_slip #(.WRAP(WRAP)) u_delay (
        .clk_ser (clk_ser),
        .rst     (rst),
        .ser_in  (ser_in),
        .pos     (slip_pos),
        .dbit    (dbit)
      );
      sdes_word_deser #(.FACTOR(FACTOR)) u_deser (
        .clk_ser (clk_ser),
        .clk_par (clk_par),
        .rst     (rst),
        .dbit    (dbit),
        .word_o  (word_o)
      );
    end else if (MODE == sdes_pkg::CAP_DDR) begin : g_ddr
      sdes_ddr_lane u_ddr (
        .clk_ser (clk_ser),
        .clk_par (clk_par),
        .rst     (rst),
        .ser_in  (ser_in),
        .word_o  (word_o)
      );
    end else begin : g_sdr
      always_ff @(posedge clk_par) begin
        if (rst) word_o <= '0;
        else     word_o <= ser_in;
      end
    end
  endgenerate

endmodule

// File: tb/sim_serial_word_capture.sv
module sim_serial_word_capture;
  import sdes_pkg::*;

  localparam int F    = 6;
  localparam int WRAP = 4;
  localparam logic [5:0] PAT = 6'b101100;

  logic clk_ser = 1'b0, clk_par6 = 1'b0, rst = 1'b1;
  logic din_s = 1'b0, din_d = 1'b0, req = 1'b0;
  logic [5:0] w0;
  logic [1:0] w1;
  logic [0:0] w2;
  logic r0, r1, r2;

  serial_word_capture #(.MODE(CAP_WORD), .FACTOR(F), .WRAP(WRAP)) u0 (
    .clk_ser(clk_ser), .clk_par(clk_par6), .rst(rst), .ser_in(din_s),
    .align_req(req), .word_o(w0), .wrap_o(r0));
  serial_word_capture #(.MODE(CAP_DDR), .FACTOR(F), .WRAP(WRAP)) u1 (
    .clk_ser(clk_ser), .clk_par(clk_ser), .rst(rst), .ser_in(din_d),
    .align_req(req), .word_o(w1), .wrap_o(r1));
  serial_word_capture #(.MODE(CAP_SDR), .FACTOR(F), .WRAP(WRAP)) u2 (
    .clk_ser(clk_ser), .clk_par(clk_ser), .rst(rst), .ser_in(din_s),
    .align_req(req), .word_o(w2), .wrap_o(r2));

  // 125 MHz serial clock; parallel clock rises 2 ns after every F-th serial edge
  int ph = 0;
  initial begin
    forever begin
      #4 clk_ser = 1'b1;
      ph = (ph + 1) % F;
      #2;
      if (ph == 0) clk_par6 = 1'b1;
      else if (ph == F / 2) clk_par6 = 1'b0;
      #2 clk_ser = 1'b0;
    end
  end

  int checks = 0, bad = 0;
  bit started = 0, slipping = 0, rnd = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // stimulus drivers, 1 ns after each edge
  int pidx = 0;
  logic [15:0] lf = 16'hACE1;
  logic [15:0] lf2 = 16'h5A3C;
  always @(posedge clk_ser) begin
    #1;
    if (rnd) begin
      din_s = lf[0];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end else begin
      din_s = PAT[5 - pidx];
      pidx = (pidx + 1) % 6;
    end
    din_d = lf2[0];
    lf2 = {lf2[0] ^ lf2[2] ^ lf2[3] ^ lf2[5], lf2[15:1]};
  end
  always @(negedge clk_ser) begin
    #1;
    din_d = lf2[0];
    lf2 = {lf2[0] ^ lf2[2] ^ lf2[3] ^ lf2[5], lf2[15:1]};
  end

  // behavioural reference model
  bit hist[$], dl[$], rq[$];
  int mslip = 0, mcnt = 0, mwraps = 0;
  logic [5:0] mhold = '0, mword = '0;
  logic [1:0] mddr = '0;
  logic ra = 1'b0, rb = 1'b0, msdr = 1'b0;

  always @(posedge clk_ser) begin
    bit go, dbit;
    if (rst) begin
      hist = {}; dl = {}; rq = {};
      for (int i = 0; i < F; i++) begin hist.push_back(1'b0); dl.push_back(1'b0); end
      for (int i = 0; i < 3; i++) rq.push_back(1'b0);
      mslip = 0; mcnt = 0; mhold = '0; mddr = '0; ra = 1'b0; msdr = 1'b0;
    end else begin
      go = rq[1] && !rq[2];
      dbit = (mslip == 0) ? din_s : hist[mslip - 1];
      dl.push_back(dbit); void'(dl.pop_front());
      if (mcnt == F - 1)
        for (int i = 0; i < F; i++) mhold[F - 1 - i] = dl[i];
      mcnt = (mcnt + 1) % F;
      if (go) begin
        if (mslip == WRAP - 1) begin mslip = 0; mwraps++; end
        else mslip++;
      end
      hist.push_front(din_s); void'(hist.pop_back());
      rq.push_front(req); void'(rq.pop_back());
      mddr = {ra, rb};
      ra = din_d;
      msdr = din_s;
    end
  end
  always @(negedge clk_ser) rb = rst ? 1'b0 : din_d;
  always @(posedge clk_par6) mword = rst ? '0 : mhold;

  // per-cycle comparison and wrap-pulse monitoring
  int run0 = 0, run1 = 0, run2 = 0, np0 = 0, np1 = 0, np2 = 0;
  always @(negedge clk_ser) begin
    if (started) begin
      chk(w0 == mword, slipping ? "R2 u0 word after slip" : "R1 u0 word", w0, mword);
      chk(w1 == mddr, slipping ? "R8 ddr data under slip" : "R5 ddr pair", w1, mddr);
      chk(w2 == msdr, slipping ? "R8 sdr data under slip" : "R6 sdr bit", w2, msdr);
      if (r0) run0++;
      else if (run0 != 0) begin chk(run0 == F, "R4 u0 pulse width", run0, F); np0++; run0 = 0; end
      if (r1) run1++;
      else if (run1 != 0) begin chk(run1 == 1, "R4 u1 pulse width", run1, 1); np1++; run1 = 0; end
      if (r2) run2++;
      else if (run2 != 0) begin chk(run2 == 1, "R4 u2 pulse width", run2, 1); np2++; run2 = 0; end
    end
  end

  function automatic bit is_rot(logic [5:0] v);
    logic [5:0] p = PAT;
    for (int s = 0; s < 6; s++) begin
      if (v == p) return 1'b1;
      p = {p[0], p[5:1]};
    end
    return 1'b0;
  endfunction

  task automatic slip(input int n_high);
    @(posedge clk_ser); #1 req = 1'b1;
    repeat (n_high) @(posedge clk_ser);
    #1 req = 1'b0;
    repeat (40) @(posedge clk_ser);
    @(negedge clk_ser); #1;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  logic [5:0] refw, rot1;
  initial begin
    repeat (24) @(posedge clk_ser);
    @(negedge clk_ser); #1;
    chk(w0 == '0, "R7 reset u0 word", w0, 0);
    chk(w1 == '0, "R7 reset u1 word", w1, 0);
    chk(w2 == '0, "R7 reset u2 word", w2, 0);
    chk(!r0 && !r1 && !r2, "R7 reset wrap flags", {r0, r1, r2}, 0);
    @(posedge clk_ser); #1 rst = 1'b0;
    started = 1;
    repeat (60) @(posedge clk_ser);
    @(negedge clk_ser); #1;
    refw = w0;
    chk(is_rot(refw), "R1 word is a rotation of the pattern", refw, PAT);
    slipping = 1;
    slip(3);
    rot1 = w0;
    chk(rot1 == {refw[0], refw[5:1]}, "R2 one-bit rotation after slip", rot1, {refw[0], refw[5:1]});
    slip(3);
    slip(3);
    chk(w0 != refw, "R3 not yet wrapped", w0, refw);
    chk(np0 == 0, "R4 no pulse before wrap", np0, 0);
    slip(3);
    chk(w0 == refw, "R3 alignment restored after wrap", w0, refw);
    chk(np0 == 1, "R4 u0 pulse count", np0, 1);
    chk(np1 == 1, "R8 u1 wrap reported", np1, 1);
    chk(np2 == 1, "R8 u2 wrap reported", np2, 1);
    slip(20);
    chk(w0 == rot1, "R9 held request gives one slip", w0, rot1);
    slip(3);
    slip(3);
    slip(3);
    chk(w0 == refw, "R3 second wrap restores", w0, refw);
    chk(np0 == 2, "R4 u0 second pulse", np0, 2);
    rnd = 1;
    repeat (100) @(posedge clk_ser);
    for (int k = 0; k < 5; k++) slip(2 + k);
    repeat (60) @(posedge clk_ser);
    @(negedge clk_ser); #1;
    chk(np0 == mwraps, "R4 u0 pulses match wraps", np0, mwraps);
    chk(np1 == mwraps, "R4 u1 pulses match wraps", np1, mwraps);
    chk(np2 == mwraps, "R4 u2 pulses match wraps", np2, mwraps);
    done = 1;
    summary();
  end

endmodule